// File: doc/BRIEF.md
# Graceful Receive Stop Controller

This block sits on the receive side of an Ethernet port. It takes the raw byte stream from the MAC and hands frame payload bytes to a small staging FIFO. The FIFO drains through a valid/ready handshake towards the memory side. On its own, the block looks for a run of preamble bytes (0x55) followed by a start-of-frame delimiter (0xD5). It forwards every byte after the delimiter, up to and including the byte flagged as end of frame. It then moves its receive-descriptor index on by one.

Software can ask for a graceful stop at any time. A frame already under way is allowed to finish. The FIFO is then drained empty, and a sticky completion event is raised. From then on the block ignores the input stream until the request is withdrawn. After that it must see a fresh preamble and delimiter before it accepts data again, and that next frame uses the next descriptor. A separate registered path reorders the halfword and word fields of a receive descriptor when the descriptor byte order is little-endian. Frame data is never reordered.

Top module: `gstop_rx_top`

## Requirements
- R1: After synchronous reset, out_valid, frame_done, stop_evt and rx_halted are 0 and desc_idx is 0.
- R2: A frame is accepted only after at least PRE_MIN consecutive 0x55 bytes followed directly by 0xD5. The bytes that follow, up to and including the byte marked rx_eof, appear on out_data in arrival order and unaltered.
- R3: Each accepted frame gives a one-cycle frame_done pulse and advances desc_idx by one. desc_idx changes at no other time and wraps from NUM_DESC-1 to 0.
- R4: If stop_req rises in the middle of an accepted frame, that frame is still received to its rx_eof byte, and all of its bytes are delivered.
- R5: stop_evt is set only once the FIFO storage and its output register are both empty. While out_ready holds data back, stop_evt stays 0.
- R6: If stop_req is raised while no frame is in progress and the FIFO is empty, stop_evt is 1 two clock cycles later.
- R7: While the block is halted and stop_req stays 1, input bytes are discarded. Even complete, valid frames produce no output, no frame_done and no change of desc_idx.
- R8: stop_evt stays 1 until evt_clr is 1 at a clock edge, which clears it. If a clear and a new set fall in the same cycle, stop_evt ends up 1.
- R9: Once stop_req is cleared, bytes of a frame already under way on the line are not accepted. The next frame with a valid preamble and delimiter is accepted and uses the next descriptor index.
- R10: One cycle after its inputs are applied, desc_word0 is {flags, length} and desc_word1 is the pointer. When desc_le is 1, each 16-bit field has its two bytes swapped, and the 32-bit pointer has its four bytes reversed. desc_le has no effect on frame data on out_data.
- R11: A preamble shorter than PRE_MIN bytes, or one broken by any other byte, followed by 0xD5, does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | rx_byte carries a byte this cycle |
| rx_byte | input | 8 | Raw receive byte from the MAC |
| rx_eof | input | 1 | This byte is the valid last byte of a frame |
| stop_req | input | 1 | Graceful stop request bit |
| evt_clr | input | 1 | Write-one-to-clear for stop_evt |
| out_ready | input | 1 | Memory side accepts out_data |
| out_valid | output | 1 | out_data holds a payload byte |
| out_data | output | 8 | Payload byte towards memory |
| frame_done | output | 1 | One-cycle pulse: buffer closed at frame end |
| desc_idx | output | $clog2(NUM_DESC) | Receive descriptor index for the next frame |
| stop_evt | output | 1 | Sticky graceful-stop-complete event |
| rx_halted | output | 1 | Reception halted under stop request |
| desc_le | input | 1 | Descriptor byte order: 1 = little-endian |
| desc_flags | input | 16 | Descriptor flags field, logical value |
| desc_len | input | 16 | Descriptor length field, logical value |
| desc_ptr | input | 32 | Descriptor buffer pointer, logical value |
| desc_word0 | output | 32 | Memory image of flags and length |
| desc_word1 | output | 32 | Memory image of buffer pointer |

## Verification
A stuck or wrong frame-tracking state shows up at the ports within one frame. Payload bytes go missing or appear from ignored frames, frame_done pulses are miscounted, or desc_idx drifts from the count of accepted frames. A flush state that fires too early shows as stop_evt rising while out_valid is still held by a low out_ready. One that never finishes shows as stop_evt missing long after the drain. A wrong preamble counter becomes visible on the first short or broken preamble. A lost resume condition shows on the first frame after the request is dropped.

// File: rtl/gstop_pkg.sv
package gstop_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_RECV  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_HALT  = 2'd3
  } gstop_state_t;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
endpackage

// File: rtl/gstop_fifo.sv
module gstop_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         empty_all
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          pop_mem;
  logic          full;

  assign pop_mem   = (cnt != '0) && (!out_valid || out_ready);
  assign full      = (cnt == CW'(DEPTH));
  assign empty_all = (cnt == '0) && !out_valid;

  // storage and read register without reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (pop_mem) out_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_mem) begin
        rptr      <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      cnt <= cnt + CW'(wr_en) - CW'(pop_mem);
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
endmodule

// File: rtl/gstop_ctrl.sv
module gstop_ctrl
  import gstop_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int PRE_MIN  = 2,
  localparam int DIW     = $clog2(NUM_DESC),
  localparam int PCW     = $clog2(PRE_MIN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  input  logic           rx_eof,
  input  logic           stop_req,
  input  logic           evt_clr,
  input  logic           fifo_empty,
  output logic           wr_en,
  output logic           frame_done,
  output logic [DIW-1:0] desc_idx,
  output logic           stop_evt,
  output logic           halted
);
  gstop_state_t   state;
  logic [PCW-1:0] pre_cnt;
  logic           evt_set;

  assign wr_en   = (state == ST_RECV) && rx_valid;
  assign evt_set = (state == ST_FLUSH) && fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HUNT;
      pre_cnt    <= '0;
      desc_idx   <= '0;
      frame_done <= 1'b0;
      stop_evt   <= 1'b0;
      halted     <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      stop_evt   <= (stop_evt & ~evt_clr) | evt_set;
      case (state)
        ST_HUNT: begin
          if (stop_req) begin
            state   <= ST_FLUSH;
            pre_cnt <= '0;
          end else if (rx_valid) begin
            if (rx_byte == PRE_BYTE) begin
              if (pre_cnt != PCW'(PRE_MIN)) pre_cnt <= pre_cnt + 1'b1;
            end else if (rx_byte == SFD_BYTE && pre_cnt == PCW'(PRE_MIN)) begin
              state   <= ST_RECV;
              pre_cnt <= '0;
            end else begin
              pre_cnt <= '0;
            end
          end
        end
        ST_RECV: begin
          if (rx_valid && rx_eof) begin
            frame_done <= 1'b1;
            desc_idx   <= (desc_idx == DIW'(NUM_DESC - 1)) ? '0 : desc_idx + 1'b1;
            state      <= stop_req ? ST_FLUSH : ST_HUNT;
          end
        end
        ST_FLUSH: begin
          if (fifo_empty) begin
            state  <= ST_HALT;
            halted <= 1'b1;
          end
        end
        default: begin
          if (!stop_req) begin
            state   <= ST_HUNT;
            halted  <= 1'b0;
            pre_cnt <= '0;
          end
        end
      endcase
    end
  end

  assert_evt_after_drain_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_evt) |-> $past(fifo_empty));

  assert_evt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !evt_clr) |=> stop_evt);

  assert_idx_moves_on_done_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(desc_idx) |-> frame_done);

  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (halted && stop_req) |=> (halted && !wr_en));
endmodule

// File: rtl/gstop_desc_swap.sv
module gstop_desc_swap #(
  parameter int FW = 16,
  parameter int PW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           le_mode,
  input  logic [FW-1:0]  flags,
  input  logic [FW-1:0]  len,
  input  logic [PW-1:0]  ptr,
  output logic [2*FW-1:0] word0,
  output logic [PW-1:0]  word1
);
  localparam int FB = FW / 8;
  localparam int PB = PW / 8;

  logic [FW-1:0] flags_sw, len_sw;
  logic [PW-1:0] ptr_sw;

  genvar g;
  generate
    for (g = 0; g < FB; g++) begin : g_half
      assign flags_sw[8*g +: 8] = flags[8*(FB-1-g) +: 8];
      assign len_sw[8*g +: 8]   = len[8*(FB-1-g) +: 8];
    end
    for (g = 0; g < PB; g++) begin : g_word
      assign ptr_sw[8*g +: 8] = ptr[8*(PB-1-g) +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      word0 <= '0;
      word1 <= '0;
    end else if (le_mode) begin
      word0 <= {flags_sw, len_sw};
      word1 <= ptr_sw;
    end else begin
      word0 <= {flags, len};
      word1 <= ptr;
    end
  end

  assert_stable_inputs_R10: assert property (@(posedge clk) disable iff (rst)
    ($stable(le_mode) && $stable(flags) && $stable(len) && $stable(ptr)) |=> $stable(word1));
endmodule

// File: rtl/gstop_rx_top.sv
module gstop_rx_top #(
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_DESC   = 8,
  parameter int PRE_MIN    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rx_valid,
  input  logic [7:0]                  rx_byte,
  input  logic                        rx_eof,
  input  logic                        stop_req,
  input  logic                        evt_clr,
  input  logic                        out_ready,
  output logic                        out_valid,
  output logic [7:0]                  out_data,
  output logic                        frame_done,
  output logic [$clog2(NUM_DESC)-1:0] desc_idx,
  output logic                        stop_evt,
  output logic                        rx_halted,
  input  logic                        desc_le,
  input  logic [15:0]                 desc_flags,
  input  logic [15:0]                 desc_len,
  input  logic [31:0]                 desc_ptr,
  output logic [31:0]                 desc_word0,
  output logic [31:0]                 desc_word1
);
  logic wr_en;
  logic fifo_empty;

  gstop_ctrl #(.NUM_DESC(NUM_DESC), .PRE_MIN(PRE_MIN)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .rx_eof     (rx_eof),
    .stop_req   (stop_req),
    .evt_clr    (evt_clr),
    .fifo_empty (fifo_empty),
    .wr_en      (wr_en),
    .frame_done (frame_done),
    .desc_idx   (desc_idx),
    .stop_evt   (stop_evt),
    .halted     (rx_halted)
  );

  gstop_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (rx_byte),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .empty_all (fifo_empty)
  );

  gstop_desc_swap #(.FW(16), .PW(32)) u_swap (
    .clk     (clk),
    .rst     (rst),
    .le_mode (desc_le),
    .flags   (desc_flags),
    .len     (desc_len),
    .ptr     (desc_ptr),
    .word0   (desc_word0),
    .word1   (desc_word1)
  );
endmodule

// File: tb/tb_gstop_rx_top.sv
module tb_gstop_rx_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 4;
  localparam int PMIN  = 3;

  logic clk = 0, rst = 1;
  logic rx_valid = 0, rx_eof = 0, stop_req = 0, evt_clr = 0, out_ready = 0;
  logic [7:0] rx_byte = 0;
  logic out_valid, frame_done, stop_evt, rx_halted;
  logic [7:0] out_data;
  logic [1:0] desc_idx;
  logic desc_le = 0;
  logic [15:0] desc_flags = 0, desc_len = 0;
  logic [31:0] desc_ptr = 0, desc_word0, desc_word1;

  int nchk = 0, nerr = 0, ne = 0, ng = 0, nfd = 0, frames = 0;
  logic [7:0] expq [512];
  logic [7:0] gotq [512];

  gstop_rx_top #(.FIFO_DEPTH(16), .NUM_DESC(NDESC), .PRE_MIN(PMIN)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin gotq[ng] = out_data; ng++; end
    if (!rst && frame_done) nfd++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b, input logic e);
    rx_valid = 1; rx_byte = b; rx_eof = e;
    @(negedge clk);
    rx_valid = 0; rx_eof = 0;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); out_ready <= v; @(negedge clk);
  endtask

  task automatic send_frame(input int npre, input int len, input int base, input bit ok);
    for (int i = 0; i < npre; i++) put(8'h55, 0);
    put(8'hD5, 0);
    for (int i = 0; i < len; i++) begin
      put(8'(base + i), i == len - 1);
      if (ok) begin expq[ne] = 8'(base + i); ne++; end
    end
    if (ok) frames++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int s_ng, s_idx, s_fd;
    idle(3);
    rst = 0;
    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 stop_evt", stop_evt, 0);
    chk("R1 rx_halted", rx_halted, 0);
    chk("R1 desc_idx", desc_idx, 0);
    chk("R1 frame_done", frame_done, 0);

    // R2 R3: sweep lengths and preamble lengths, index wraps
    set_ready(1);
    for (int f = 0; f < 6; f++) begin
      send_frame(PMIN + (f % 3), f + 1, 16 * (f + 1), 1);
      idle(3);
      chk("R3 desc_idx", desc_idx, frames % NDESC);
    end
    chk("R3 frame_done count", nfd, frames);
    chk("R2 byte count", ng, ne);

    // R11: short and broken preambles
    s_idx = desc_idx; s_ng = ng;
    send_frame(PMIN - 1, 3, 8'hA0, 0);
    put(8'h55, 0); put(8'h55, 0); put(8'h0F, 0); put(8'h55, 0);
    send_frame(0, 2, 8'hB0, 0);
    idle(4);
    chk("R11 no bytes", ng, s_ng);
    chk("R11 desc_idx", desc_idx, s_idx);
    send_frame(PMIN, 2, 8'hC0, 1);
    idle(4);
    chk("R11 resync", ng, ne);

    // R4 R5: stop mid-frame with drain held back
    set_ready(0);
    for (int i = 0; i < PMIN; i++) put(8'h55, 0);
    put(8'hD5, 0);
    for (int i = 0; i < 6; i++) begin
      if (i == 2) stop_req = 1;
      put(8'(8'h60 + i), i == 5);
      expq[ne] = 8'(8'h60 + i); ne++;
    end
    frames++;
    idle(6);
    chk("R5 evt before drain", stop_evt, 0);
    chk("R5 not halted before drain", rx_halted, 0);
    set_ready(1);
    idle(20);
    chk("R5 evt after drain", stop_evt, 1);
    chk("R4 halted", rx_halted, 1);
    chk("R4 bytes delivered", ng, ne);
    chk("R3 idx after stop frame", desc_idx, frames % NDESC);

    // R7: input ignored while halted
    s_ng = ng; s_idx = desc_idx; s_fd = nfd;
    send_frame(PMIN, 4, 8'h70, 0);
    send_frame(PMIN + 2, 3, 8'h78, 0);
    idle(4);
    chk("R7 no bytes", ng, s_ng);
    chk("R7 desc_idx", desc_idx, s_idx);
    chk("R7 frame_done", nfd, s_fd);
    chk("R7 still halted", rx_halted, 1);

    // R8: sticky, then clear
    chk("R8 sticky", stop_evt, 1);
    evt_clr = 1; @(negedge clk); evt_clr = 0;
    chk("R8 cleared", stop_evt, 0);

    // R9: resume in the middle of a frame on the line
    for (int i = 0; i < PMIN; i++) put(8'h55, 0);
    put(8'hD5, 0);
    put(8'h01, 0); put(8'h02, 0);
    stop_req = 0;
    put(8'h03, 0); put(8'h04, 0); put(8'h05, 1);
    idle(4);
    chk("R9 mid-frame dropped", ng, s_ng);
    chk("R9 resumed", rx_halted, 0);
    send_frame(PMIN, 3, 8'h90, 1);
    idle(4);
    chk("R9 next frame bytes", ng, ne);
    chk("R9 next descriptor", desc_idx, (s_idx + 1) % NDESC);

    // R6 R8: stop while idle, clear in the same cycle as the set
    stop_req = 1; evt_clr = 1;
    @(negedge clk); @(negedge clk);
    evt_clr = 0;
    chk("R6 evt within two cycles", stop_evt, 1);
    chk("R8 set wins over clear", stop_evt, 1);
    stop_req = 0;
    idle(3);
    evt_clr = 1; @(negedge clk); evt_clr = 0;

    // R10: descriptor byte order sweep, and data unaffected
    for (int le = 0; le < 2; le++) begin
      for (int k = 0; k < 8; k++) begin
        logic [15:0] fl, ln;
        logic [31:0] pt, e0, e1;
        fl = 16'(16'h1234 * (k + 1) + 3 * k);
        ln = 16'(16'h0101 * k + 16'h0A0B);
        pt = 32'h0102_0304 * (k + 1) + 32'h9000_0000;
        desc_le = 1'(le); desc_flags = fl; desc_len = ln; desc_ptr = pt;
        @(negedge clk);
        if (le == 1) begin
          e0 = {fl[7:0], fl[15:8], ln[7:0], ln[15:8]};
          e1 = {pt[7:0], pt[15:8], pt[23:16], pt[31:24]};
        end else begin
          e0 = {fl, ln};
          e1 = pt;
        end
        chk("R10 word0", desc_word0, e0);
        chk("R10 word1", desc_word1, e1);
      end
    end
    send_frame(PMIN, 4, 8'h31, 1);
    idle(4);
    chk("R10 data order count", ng, ne);

    // R2: full byte stream comparison
    for (int i = 0; i < ne; i++) chk("R2 byte", gotq[i], expq[i]);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule